// File: doc/BRIEF.md
# Sample FIFO with Block Interrupt

This block buffers converter samples between a converter write strobe and a host read port. It holds 1024 samples of 16 bits each. It keeps an empty status, a sticky overrun flag and a single latched interrupt line. The host clears the interrupt line with an acknowledge pulse.

The interrupt source depends on the trigger mode. When conversions are started one at a time by software, every stored sample raises the interrupt. In paced operation the interrupt fires each time the fill level reaches half the depth (512). The host then drains a full block in one burst.

A capture whose length is not a multiple of 512 ends with a partial block. To handle it, the host loads the size of that partial block into a residual down-counter, turns on enhanced mode and sets the residual gate. The half-full interrupt that closes the last full block arms the counter. Each later stored sample counts it down, and reaching zero raises a final interrupt. This scheme only makes sense when the total capture exceeds 512 samples.

Top module: `sample_buffer_irq`

## Requirements
- R1: Samples are returned in write order. The FIFO holds 1024 entries of 16 bits. Read data appears on `rdData` in the cycle after the clock edge that samples `rdStb`.
- R2: A write strobe while 1024 samples are stored is dropped. The stored contents and their order are unchanged.
- R3: A read strobe while the FIFO is empty leaves `rdData` at its previous value and moves no pointer.
- R4: `fifoEmpty` is 1 when no sample is stored and 0 when at least one is stored.
- R5: `overrun` sets when the level reaches 1024. It stays set until a clear pulse; reads do not clear it.
- R6: `clrStb` empties the FIFO and clears `overrun`. It takes priority over a write or read strobe in the same cycle.
- R7: With `pacedMode` = 0 (software trigger), every accepted write sets `irqFlag`.
- R8: With `pacedMode` = 1, `irqFlag` sets when a write takes the level from 511 to 512. It sets again each later time the level climbs back to 512.
- R9: `irqAck` clears `irqFlag`. If a set event occurs in the same cycle as the acknowledge, the set wins.
- R10: `resLoad` loads `resLoadVal` into the residual counter. With `enhMode` = 1 and `resGate` = 1, a half-full event in paced mode arms the counter. Each later accepted write decrements it, and the write that brings it to zero sets `irqFlag`.
- R11: Residual counting needs both `enhMode` and `resGate` high. With either one low, no final interrupt is raised after the last half-full event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStb | input | 1 | Converter sample write strobe |
| wrData | input | 16 | Sample to store |
| rdStb | input | 1 | Host read strobe |
| rdData | output | 16 | Oldest sample, registered |
| clrStb | input | 1 | FIFO clear pulse |
| pacedMode | input | 1 | 0 = software trigger, 1 = paced (block interrupts) |
| enhMode | input | 1 | Enables the residual counter |
| resGate | input | 1 | Gates residual counting |
| resLoad | input | 1 | Loads the residual counter |
| resLoadVal | input | 16 | Residual sample count |
| irqAck | input | 1 | Clears the interrupt latch |
| fifoEmpty | output | 1 | 1 when the FIFO holds no sample |
| overrun | output | 1 | Sticky full indication |
| irqFlag | output | 1 | Latched interrupt |

## Verification
A wrong level counter shows up first at the ports as a misplaced half-full interrupt or a misplaced overrun. The bench pins both to the exact write that should cause them: the 512th and the 1024th. A broken pointer shows as a wrong word on `rdData` one cycle after the read strobe. Every sample is compared against a queue of the values written, including after a dropped write and after the read pointer wraps. A residual counter that counts the wrong writes, or counts while ungated, moves the final interrupt by at least one write. The bench checks the flag just before and just after the expected write.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  typedef struct packed {
    logic push;
    logic pop;
    logic clear;
    logic arm;
  } ctrlStrobes_t;
endpackage

// File: rtl/sbf_datapath.sv
module sbf_datapath #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = PTR_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sbf_pkg::ctrlStrobes_t strb,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [LVL_W-1:0]     level
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (strb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (strb.push) wrPtr <= wrPtr + PTR_W'(1);
      if (strb.pop)  rdPtr <= rdPtr + PTR_W'(1);
      case ({strb.push, strb.pop})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (strb.pop)  rdData <= mem[rdPtr];
  end
endmodule

// File: rtl/sbf_residual.sv
module sbf_residual #(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sbf_pkg::ctrlStrobes_t strb,
  input  logic                 enhMode,
  input  logic                 resGate,
  input  logic                 resLoad,
  input  logic [CNT_W-1:0]     resLoadVal,
  output logic                 termEvt
);
  logic [CNT_W-1:0] resCnt;
  logic             armed;
  logic             cntDec;

  assign cntDec  = armed && strb.push && enhMode && resGate;
  assign termEvt = cntDec && (resCnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resCnt <= '0;
      armed  <= 1'b0;
    end else if (resLoad) begin
      resCnt <= resLoadVal;
      armed  <= 1'b0;
    end else if (strb.clear) begin
      armed  <= 1'b0;
    end else if (strb.arm) begin
      armed  <= (resCnt != '0);
    end else if (cntDec) begin
      resCnt <= resCnt - CNT_W'(1);
      if (resCnt == CNT_W'(1)) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/sbf_control.sv
module sbf_control #(
  parameter int DEPTH = 1024,
  parameter int BLOCK = 512,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrStb,
  input  logic                  rdStb,
  input  logic                  clrStb,
  input  logic                  pacedMode,
  input  logic                  enhMode,
  input  logic                  resGate,
  input  logic                  irqAck,
  input  logic                  termEvt,
  input  logic [LVL_W-1:0]      level,
  output sbf_pkg::ctrlStrobes_t strb,
  output logic                  fifoEmpty,
  output logic                  overrun,
  output logic                  irqFlag
);
  logic fifoFull;
  logic hfEvt;
  logic fillEvt;
  logic setIrq;

  assign fifoEmpty = (level == '0);
  assign fifoFull  = (level == LVL_W'(DEPTH));

  always_comb begin
    strb       = '0;
    strb.clear = clrStb;
    strb.push  = wrStb && !fifoFull && !clrStb;
    strb.pop   = rdStb && !fifoEmpty && !clrStb;
    hfEvt      = strb.push && !strb.pop && (level == LVL_W'(BLOCK - 1));
    fillEvt    = strb.push && !strb.pop && (level == LVL_W'(DEPTH - 1));
    strb.arm   = hfEvt && pacedMode && enhMode && resGate;
    setIrq     = (pacedMode ? hfEvt : strb.push) || termEvt;
  end

  always_ff @(posedge clk) begin
    if (!rstN)         overrun <= 1'b0;
    else if (clrStb)   overrun <= 1'b0;
    else if (fillEvt)  overrun <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        irqFlag <= 1'b0;
    else if (setIrq)  irqFlag <= 1'b1;
    else if (irqAck)  irqFlag <= 1'b0;
  end
endmodule

// File: rtl/sample_buffer_irq.sv
module sample_buffer_irq #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  parameter int BLOCK  = 512,
  parameter int CNT_W  = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStb,
  output logic [DATA_W-1:0] rdData,
  input  logic              clrStb,
  input  logic              pacedMode,
  input  logic              enhMode,
  input  logic              resGate,
  input  logic              resLoad,
  input  logic [CNT_W-1:0]  resLoadVal,
  input  logic              irqAck,
  output logic              fifoEmpty,
  output logic              overrun,
  output logic              irqFlag
);
  sbf_pkg::ctrlStrobes_t strb;
  logic [LVL_W-1:0]      level;
  logic                  termEvt;

  sbf_control #(.DEPTH(DEPTH), .BLOCK(BLOCK)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb), .clrStb(clrStb),
    .pacedMode(pacedMode), .enhMode(enhMode), .resGate(resGate),
    .irqAck(irqAck), .termEvt(termEvt), .level(level), .strb(strb),
    .fifoEmpty(fifoEmpty), .overrun(overrun), .irqFlag(irqFlag)
  );

  sbf_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .rdData(rdData), .level(level)
  );

  sbf_residual #(.CNT_W(CNT_W)) u_res (
    .clk(clk), .rstN(rstN), .strb(strb), .enhMode(enhMode),
    .resGate(resGate), .resLoad(resLoad), .resLoadVal(resLoadVal),
    .termEvt(termEvt)
  );
endmodule

// File: rtl/sbf_checker.sv
module sbf_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrStb,
  input logic              rdStb,
  input logic              clrStb,
  input logic              pacedMode,
  input logic              irqAck,
  input logic [DATA_W-1:0] rdData,
  input logic              fifoEmpty,
  input logic              overrun,
  input logic              irqFlag
);
  AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && fifoEmpty) |=> $stable(rdData)); // R3

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rstN)
    clrStb |=> fifoEmpty); // R6

  AST_CLEAR_DROPS_OVERRUN: assert property (@(posedge clk) disable iff (!rstN)
    clrStb |=> !overrun); // R5

  AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !clrStb) |=> overrun); // R5

  AST_SOFT_WRITE_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (!pacedMode && wrStb && fifoEmpty && !clrStb) |=> irqFlag); // R7

  AST_ACK_CLEARS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (irqAck && !wrStb) |=> !irqFlag); // R9

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !irqAck) |=> irqFlag); // R9
endmodule

bind sample_buffer_irq sbf_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .rdStb(rdStb), .clrStb(clrStb),
  .pacedMode(pacedMode), .irqAck(irqAck), .rdData(rdData),
  .fifoEmpty(fifoEmpty), .overrun(overrun), .irqFlag(irqFlag)
);

// File: tb/sample_buffer_irq_bench.sv
module sample_buffer_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;
  localparam int BLOCK = 512;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdStb = 1'b0;
  logic [15:0] rdData;
  logic        clrStb = 1'b0;
  logic        pacedMode = 1'b0;
  logic        enhMode = 1'b0;
  logic        resGate = 1'b0;
  logic        resLoad = 1'b0;
  logic [15:0] resLoadVal = '0;
  logic        irqAck = 1'b0;
  logic        fifoEmpty;
  logic        overrun;
  logic        irqFlag;

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;
  logic [15:0] expQ[$];
  logic [15:0] lastRead = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_buffer_irq u_sample_buffer_irq (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .rdStb(rdStb),
    .rdData(rdData), .clrStb(clrStb), .pacedMode(pacedMode),
    .enhMode(enhMode), .resGate(resGate), .resLoad(resLoad),
    .resLoadVal(resLoadVal), .irqAck(irqAck), .fifoEmpty(fifoEmpty),
    .overrun(overrun), .irqFlag(irqFlag)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: pushes expected items for accepted writes
  task automatic drvWrite(logic [15:0] val);
    wrStb = 1'b1; wrData = val;
    tick();
    wrStb = 1'b0;
    if (expQ.size() < DEPTH) expQ.push_back(val);
  endtask

  // monitor side: pops the expected item as the design returns it
  task automatic monRead(string req);
    logic [15:0] exp;
    rdStb = 1'b1;
    tick();
    rdStb = 1'b0;
    if (expQ.size() > 0) exp = expQ.pop_front();
    else exp = lastRead;
    check(req, rdData, exp);
    lastRead = rdData;
  endtask

  task automatic pulseAck();
    irqAck = 1'b1; tick(); irqAck = 1'b0;
  endtask

  task automatic pulseClear();
    clrStb = 1'b1; tick(); clrStb = 1'b0;
    expQ.delete();
  endtask

  task automatic loadResidual(logic [15:0] v);
    resLoadVal = v; resLoad = 1'b1; tick(); resLoad = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    // reset state
    check("R4 reset empty", fifoEmpty, 1);
    check("R5 reset overrun", overrun, 0);
    check("R9 reset irq", irqFlag, 0);
    check("R1 reset rdData", rdData, 0);

    // software trigger mode
    drvWrite(16'h1234);
    check("R7 irq on write", irqFlag, 1);
    check("R4 not empty", fifoEmpty, 0);
    pulseAck();
    check("R9 ack clears", irqFlag, 0);
    drvWrite(16'hABCD);
    check("R7 irq second write", irqFlag, 1);
    // set and ack in same cycle: set wins
    irqAck = 1'b1; drvWrite(16'h0F0F); irqAck = 1'b0;
    check("R9 set beats ack", irqFlag, 1);
    pulseAck();
    monRead("R1 order 0");
    monRead("R1 order 1");
    monRead("R1 order 2");
    check("R4 empty after drain", fifoEmpty, 1);
    monRead("R3 empty read holds");
    check("R3 still empty", fifoEmpty, 1);
    drvWrite(16'h5555);
    monRead("R3 pointer unmoved");

    // clear priority over write
    clrStb = 1'b1; wrStb = 1'b1; wrData = 16'h7777;
    tick();
    clrStb = 1'b0; wrStb = 1'b0;
    expQ.delete();
    check("R6 clear beats write", fifoEmpty, 1);
    pulseAck();

    // paced block interrupt
    pacedMode = 1'b1;
    for (int i = 0; i < BLOCK - 1; i++) drvWrite(16'(i + 100));
    check("R8 no irq at 511", irqFlag, 0);
    drvWrite(16'(BLOCK - 1 + 100));
    check("R8 irq at 512", irqFlag, 1);
    pulseAck();
    for (int i = 0; i < 88; i++) drvWrite(16'(i + 2000));
    check("R8 no irq above 512", irqFlag, 0);
    for (int i = 0; i < 100; i++) monRead("R1 paced data");
    for (int i = 0; i < 11; i++) drvWrite(16'(i + 3000));
    check("R8 no irq at 511 again", irqFlag, 0);
    drvWrite(16'h3FFF);
    check("R8 irq re-fires at 512", irqFlag, 1);
    pulseAck();
    check("R11 no residual ungated", irqFlag, 0);
    pulseClear();
    check("R6 clear empties", fifoEmpty, 1);

    // fill, overrun, drop
    pacedMode = 1'b0;
    for (int i = 0; i < DEPTH - 1; i++) drvWrite(16'(i * 7 + 3));
    check("R5 no overrun at 1023", overrun, 0);
    drvWrite(16'hBEEF);
    check("R5 overrun at 1024", overrun, 1);
    drvWrite(16'hDEAD);
    for (int i = 0; i < DEPTH; i++) monRead("R2 full drop and order");
    check("R4 empty after full drain", fifoEmpty, 1);
    check("R5 overrun sticky after reads", overrun, 1);
    monRead("R3 empty read after wrap");
    pulseClear();
    check("R6 clear drops overrun", overrun, 0);
    pulseAck();

    // residual final interrupt
    pacedMode = 1'b1; enhMode = 1'b1; resGate = 1'b1;
    loadResidual(16'd5);
    for (int i = 0; i < BLOCK; i++) drvWrite(16'(i));
    check("R10 last block irq", irqFlag, 1);
    pulseAck();
    for (int i = 0; i < 4; i++) drvWrite(16'(i + 600));
    check("R10 no irq before terminal", irqFlag, 0);
    drvWrite(16'd777);
    check("R10 irq at terminal count", irqFlag, 1);
    pulseAck();
    drvWrite(16'd778);
    check("R10 no irq after terminal", irqFlag, 0);
    pulseClear();

    // residual gate low
    resGate = 1'b0;
    loadResidual(16'd3);
    for (int i = 0; i < BLOCK; i++) drvWrite(16'(i));
    check("R8 block irq gate low", irqFlag, 1);
    pulseAck();
    for (int i = 0; i < 3; i++) drvWrite(16'(i));
    check("R11 gate low no final irq", irqFlag, 0);
    pulseClear();

    // enhanced mode off
    enhMode = 1'b0; resGate = 1'b1;
    loadResidual(16'd2);
    for (int i = 0; i < BLOCK; i++) drvWrite(16'(i));
    pulseAck();
    for (int i = 0; i < 2; i++) drvWrite(16'(i));
    check("R11 enhanced off no final irq", irqFlag, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule